// File: doc/BRIEF.md
# Oversampled Asynchronous Static RAM Emulator

This block stands in for the memory side of an asynchronous byte-wide static RAM, running entirely from a fast system clock. A bus master drives its usual pins: an active-low select, an active-high select, an active-low output enable, an active-low write strobe, an 18-bit address and 8 data bits. The block oversamples these pins, decodes the access mode, and answers. The answer is read data plus a separate drive-enable for a tri-state pad. A master can therefore be exercised against it inside a chip or on a board.

All pins pass through a two-flop synchroniser. The decoder then classifies each sampled cycle as standby, selected-but-quiet, read or write. A write window is the overlap of the three write conditions. The window opens when the last of them becomes true and closes when the first of them becomes false. While the window is open, the block keeps the most recent sampled address and data. It commits them to an internal register array in the cycle the window is seen to close.

The array depth is a parameter well below the full address space, so the block fits in flops. The address wraps modulo the depth.

Top module: `sram_emu`

## Requirements
- R1: Each word is 8 bits. The stored location is the address modulo DEPTH (default 256), so address bits above the index select nothing.
- R2: While sel_n_i is high or sel_i is low (standby), dout_oe_o is low and no word is stored.
- R3: While sel_n_i is low, sel_i high, rd_n_i high and wr_n_i high, dout_oe_o is low and no word is stored.
- R4: While sel_n_i is low, sel_i high, rd_n_i low and wr_n_i high, dout_oe_o is high and dout_o carries the word at the current address.
- R5: A write window is open exactly while sel_n_i is low, sel_i is high and wr_n_i is low, whatever rd_n_i is. dout_oe_o stays low for the whole window.
- R6: Exactly one word is stored per window, when it closes. The close may come from sel_n_i rising, sel_i falling or wr_n_i rising. If any one of the three conditions never holds, nothing is stored.
- R7: The stored address and data are those sampled in the last cycle the window was open. Values that change together with the closing edge are not stored (zero hold time).
- R8: A pin change reaches the outputs on the third rising clock edge after it is applied: two synchroniser stages and one output register. This includes an address change during a read.
- R9: When a window closes in the same sampled cycle that a read of the same address begins, the read returns the newly stored word.
- R10: rst_n is asynchronous and active low. It clears dout_o, dout_oe_o and every stored word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Active-high chip select |
| rd_n_i | input | 1 | Active-low output enable |
| wr_n_i | input | 1 | Active-low write strobe |
| addr_i | input | ADDR_W (18) | Word address |
| din_i | input | DATA_W (8) | Data from the bus master |
| dout_o | output | DATA_W (8) | Read data toward the pad |
| dout_oe_o | output | 1 | Drive enable for the tri-state pad |

## Verification
A write commit and a read can fall in the same sampled cycle. This happens when a window is held with the output enable already low and is then ended by the write strobe rising, so that the very next sampled cycle is a read of the just-written address. The bench provokes this with a directed sequence. It also provokes it through random writes that end on the write strobe with the output enable held low. In each case the data pins change at the same moment the window closes. The bench judges the case by sampling the output on exactly the third rising edge after the strobe rises and comparing it with the new word, not the old one.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_QUIET   = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } bus_mode_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic rd_n;
        logic wr_n;
    } ctrl_t;

    localparam logic [3:0] CTRL_IDLE = 4'b1011;

endpackage

// File: rtl/sram_emu_sync.sv
module sram_emu_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = d_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{meta: RST_VAL, stable: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.stable;

endmodule

// File: rtl/sram_emu_decode.sv
module sram_emu_decode
    import sram_emu_pkg::*;
(
    input  ctrl_t     ctrl_i,
    output bus_mode_e mode_o
);

    always_comb begin
        if (ctrl_i.sel_n || !ctrl_i.sel) begin
            mode_o = MODE_STANDBY;
        end else if (!ctrl_i.wr_n) begin
            mode_o = MODE_WRITE;
        end else if (!ctrl_i.rd_n) begin
            mode_o = MODE_READ;
        end else begin
            mode_o = MODE_QUIET;
        end
    end

endmodule

// File: rtl/sram_emu_window.sv
module sram_emu_window #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_act_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              commit_o,
    output logic [IDX_W-1:0]  commit_idx_o,
    output logic [DATA_W-1:0] commit_data_o
);

    typedef struct packed {
        logic              open;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } win_t;

    win_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.open = wr_act_i;
        if (wr_act_i) begin
            st_d.idx  = idx_i;
            st_d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o      = st_q.open && !wr_act_i;
    assign commit_idx_o  = st_q.idx;
    assign commit_data_o = st_q.data;

endmodule

// File: rtl/sram_emu_store.sv
module sram_emu_store #(
    parameter int DEPTH  = 256,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_oe_o
);

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] data;
    } rd_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    rd_t               rd_d, rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    always_comb begin
        rd_d.oe = rd_en_i;
        if (wr_en_i && (wr_idx_i == rd_idx_i)) begin
            rd_d.data = wr_data_i;
        end else begin
            rd_d.data = mem_q[rd_idx_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign dout_o    = rd_q.data;
    assign dout_oe_o = rd_q.oe;

    // R9
    same_cycle_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && rd_en_i && (wr_idx_i == rd_idx_i)) |=> (dout_o == $past(wr_data_i)));

endmodule

// File: rtl/sram_emu.sv
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              sel_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_oe_o
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [3:0]        s_ctrl_v;
    ctrl_t             s_ctrl;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;
    logic [IDX_W-1:0]  s_idx;
    bus_mode_e         mode;
    logic              commit;
    logic [IDX_W-1:0]  commit_idx;
    logic [DATA_W-1:0] commit_data;

    sram_emu_sync #(.WIDTH(4), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sel_n_i, sel_i, rd_n_i, wr_n_i}),
        .q_o   (s_ctrl_v)
    );

    sram_emu_sync #(.WIDTH(ADDR_W), .RST_VAL('0)) u_sync_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (addr_i),
        .q_o   (s_addr)
    );

    sram_emu_sync #(.WIDTH(DATA_W), .RST_VAL('0)) u_sync_data (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (din_i),
        .q_o   (s_data)
    );

    assign s_ctrl = ctrl_t'(s_ctrl_v);
    assign s_idx  = IDX_W'(s_addr % ADDR_W'(DEPTH));

    sram_emu_decode u_decode (
        .ctrl_i (s_ctrl),
        .mode_o (mode)
    );

    sram_emu_window #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_window (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_act_i      (mode == MODE_WRITE),
        .idx_i         (s_idx),
        .data_i        (s_data),
        .commit_o      (commit),
        .commit_idx_o  (commit_idx),
        .commit_data_o (commit_data)
    );

    sram_emu_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (commit),
        .wr_idx_i  (commit_idx),
        .wr_data_i (commit_data),
        .rd_en_i   (mode == MODE_READ),
        .rd_idx_i  (s_idx),
        .dout_o    (dout_o),
        .dout_oe_o (dout_oe_o)
    );

    // R2
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STANDBY) |=> !dout_oe_o);

    // R4
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_READ) |=> dout_oe_o);

    // R5
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WRITE) |=> !dout_oe_o);

    // R6
    close_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode == MODE_WRITE) |-> commit);

    // R7
    last_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (commit_data == $past(s_data) && commit_idx == $past(s_idx)));

endmodule

// File: tb/sram_emu_test.sv
`timescale 1ns/1ps
module sram_emu_test;

    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sel = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_oe;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [7:0] exp_mem [DEPTH];

    always #4 clk = ~clk;

    sram_emu uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n_i   (sel_n),
        .sel_i     (sel),
        .rd_n_i    (rd_n),
        .wr_n_i    (wr_n),
        .addr_i    (addr),
        .din_i     (din),
        .dout_o    (dout),
        .dout_oe_o (dout_oe)
    );

    function automatic int slot(input logic [17:0] a);
        return int'(a) % DEPTH;
    endfunction

    function automatic logic [7:0] exp_word(input logic [17:0] a);
        return exp_mem[slot(a)];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic go_idle();
        sel_n = 1'b1; sel = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
        settle();
    endtask

    // ender: 0 = select-low rises, 1 = select-high falls, 2 = strobe rises
    task automatic do_write(input logic [17:0] a, input logic [7:0] d,
                            input int ender, input bit oe_low);
        addr = a; din = ~d; rd_n = oe_low ? 1'b0 : 1'b1;
        settle();
        wr_n = 1'b0; settle();
        sel = 1'b1;  settle();
        sel_n = 1'b0; settle();
        check("R5 no drive during window", {7'd0, dout_oe}, 8'd0);
        din = d; settle();
        case (ender)
            0:       sel_n = 1'b1;
            1:       sel = 1'b0;
            default: wr_n = 1'b1;
        endcase
        din = 8'($urandom);
        addr = a + 18'd1;
        settle();
        exp_mem[slot(a)] = d;
        go_idle();
    endtask

    // missing: 0 = select-low held high, 1 = select-high held low, 2 = strobe held high
    task automatic do_nowrite(input logic [17:0] a, input int missing);
        addr = a; din = 8'($urandom); rd_n = 1'b1;
        sel_n = (missing == 0); sel = (missing != 1); wr_n = (missing == 2);
        settle();
        din = 8'($urandom); settle();
        check((missing == 2) ? "R3 quiet no drive" : "R2 standby no drive",
              {7'd0, dout_oe}, 8'd0);
        go_idle();
    endtask

    task automatic do_read(input logic [17:0] a, input string req);
        addr = a; sel_n = 1'b0; sel = 1'b1; wr_n = 1'b1; rd_n = 1'b0;
        settle();
        check({req, " drive enable"}, {7'd0, dout_oe}, 8'd1);
        check(req, dout, exp_word(a));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd7351));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'd0;

        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 reset dout", dout, 8'd0);
        check("R10 reset drive enable", {7'd0, dout_oe}, 8'd0);
        rst_n = 1'b1;
        settle();
        do_read(18'd77, "R10 cleared word");
        go_idle();

        // R6: each closing condition stores
        do_write(18'd10, 8'hA1, 0, 1'b0); do_read(18'd10, "R6 close by select-low");  go_idle();
        do_write(18'd11, 8'hB2, 1, 1'b0); do_read(18'd11, "R6 close by select-high"); go_idle();
        do_write(18'd12, 8'hC3, 2, 1'b0); do_read(18'd12, "R6 close by strobe");      go_idle();
        // R7: neighbour must not pick up the changed-at-close data/address
        do_read(18'd13, "R7 no store at close address"); go_idle();

        // R6/R2/R3: partial windows store nothing
        do_nowrite(18'd10, 0); do_read(18'd10, "R2 missing select-low"); go_idle();
        do_nowrite(18'd11, 1); do_read(18'd11, "R2 missing select-high"); go_idle();
        do_nowrite(18'd12, 2); do_read(18'd12, "R3 missing strobe"); go_idle();

        // R1: wrap modulo depth
        do_write(18'h00105, 8'h9C, 2, 1'b0);
        do_read(18'd5, "R1 wrapped write");
        do_read(18'h3FF05, "R1 alias read");
        go_idle();

        // R8: address change latency during read
        do_write(18'd20, 8'h11, 2, 1'b0);
        do_write(18'd21, 8'h22, 0, 1'b0);
        do_read(18'd20, "R4 read");
        addr = 18'd21;
        repeat (2) @(negedge clk);
        check("R8 old word after two edges", dout, 8'h11);
        @(negedge clk);
        check("R8 new word on third edge", dout, 8'h22);
        // R8: output enable latency from quiet
        rd_n = 1'b1; settle();
        check("R3 quiet drive enable", {7'd0, dout_oe}, 8'd0);
        rd_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 enable off after two edges", {7'd0, dout_oe}, 8'd0);
        @(negedge clk);
        check("R8 enable on third edge", {7'd0, dout_oe}, 8'd1);
        go_idle();

        // R9: commit and read of same address in one sampled cycle
        do_write(18'd30, 8'h33, 1, 1'b0);
        addr = 18'd30; din = 8'h5A;
        sel_n = 1'b0; sel = 1'b1; rd_n = 1'b0; wr_n = 1'b0;
        settle();
        check("R5 window with enable low", {7'd0, dout_oe}, 8'd0);
        wr_n = 1'b1; din = 8'hE7;
        repeat (2) @(negedge clk);
        check("R5 still in window", {7'd0, dout_oe}, 8'd0);
        @(negedge clk);
        check("R9 forwarded word", dout, 8'h5A);
        exp_mem[30] = 8'h5A;
        go_idle();
        do_read(18'd30, "R9 word kept");
        go_idle();

        // random mix
        for (int it = 0; it < 150; it++) begin
            logic [17:0] a;
            int op;
            a  = {8'($urandom), 2'd0, 8'($urandom % 16)};
            op = int'($urandom % 4);
            case (op)
                0, 1: begin
                    int  en;
                    bit  ol;
                    en = int'($urandom % 3);
                    ol = 1'($urandom);
                    if (ol && en == 2) begin
                        logic [7:0] d;
                        d = 8'($urandom);
                        addr = a; din = d;
                        sel_n = 1'b0; sel = 1'b1; rd_n = 1'b0; wr_n = 1'b0;
                        settle();
                        wr_n = 1'b1; din = ~d;
                        repeat (3) @(negedge clk);
                        check("R9 random forward", dout, d);
                        exp_mem[slot(a)] = d;
                        go_idle();
                    end else begin
                        do_write(a, 8'($urandom), en, ol);
                    end
                end
                2: begin
                    do_read(a, "R4 random read");
                    go_idle();
                end
                default: begin
                    do_nowrite(a, int'($urandom % 3));
                    do_read(a, "R6 random no store");
                    go_idle();
                end
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule